// File: doc/BRIEF.md
# GPIO Port Interrupt Controller

This unit raises interrupts from the eight input pins of one GPIO port. For each pin, software selects edge or level sensitivity in one register and the active sense (rising/high or falling/low) in a second register. A per-pin enable gates every source. An optional per-pin glitch filter can sit between the synchroniser and the detector. Edge events are held until software acknowledges them by writing ones to an acknowledge register. Level sources follow the live input.

The pending, enabled sources appear in a readable status register. They also drive the outputs in two forms: one interrupt line per pin, and one combined line that is the OR of all of them. The port can therefore be wired either to one shared vector or to eight separate ones. A line detects one edge direction at a time. To detect both edges, software flips the sense bit after each event.

Each pin passes through a two-flop synchroniser. The glitch filter is a two-state machine for each pin:
- **FLT_STEADY**: the synchronised input matches the filtered value. The transition *start* moves the machine to FLT_SETTLE when the two differ.
- **FLT_SETTLE**: a run of differing samples is being counted. The transition *reject* returns to FLT_STEADY when the input goes back to the filtered value. The transition *accept* returns to FLT_STEADY and takes the new value once the difference has been seen on the required number of consecutive clocks.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset, every control register reads 0, the status register reads 0, and `irq_line` and `irq_any` are 0.
- R2: The register addresses are as follows:
  - Register map:
    - 0: edge-select (1 = edge, 0 = level)
    - 1: sense (1 = rising/high, 0 = falling/low)
    - 2: acknowledge, write-only, reads 0
    - 3: enable
    - 4: filter enable
    - 5: status, read-only
  - Bit i of each register belongs to pin i.
  - Control registers read back the value written.
  - A write to status has no effect.
- R3: With edge-select=1 and sense=1, a rising pin sets its status bit on the third clock edge after the pin changes. The bit then stays set after the pin returns low. A status bit is never set without a detected event.
- R4: With edge-select=1 and sense=0, a falling edge sets the status bit and a rising edge does not.
- R5: With edge-select=0, the status bit follows the synchronised input, true when the input equals the sense bit. It is due on the second clock edge after the pin changes, and an acknowledge write does not clear it.
- R6: Writing a mask to the acknowledge register clears the latched edge of each bit written 1. Bits written 0 have no effect.
- R7: If a new edge event occurs on the same clock as an acknowledge of that bit, the bit stays set.
- R8: A pin whose enable bit is 0 shows no status and drives no interrupt. Edges that occur while the pin is disabled are not recorded.
- R9: `irq_line[i]` equals status bit i, and `irq_any` is 1 exactly when any status bit is set.
- R10: With filter enable=1, a changed input is only passed to the detector after it has differed from the filtered value on 4 consecutive clocks. A pulse lasting 3 clocks is ignored, and a held edge sets status 7 clock edges after the pin change.
- R11: With filter enable=0, the synchronised value goes to the detector directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 8 | Asynchronous port pin inputs |
| bus_addr | input | 3 | Register select |
| bus_we | input | 1 | Write strobe, one register per clock |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| irq_line | output | 8 | Per-pin interrupt outputs |
| irq_any | output | 1 | OR of all per-pin interrupts |

## Verification
Results are due at fixed latencies after a pin change:
- Level status is due 2 clock edges later.
- Unfiltered edge status is due 3 clock edges later.
- Filtered edge status is due 7 clock edges later.
- A register write or acknowledge takes effect on the clock edge that samples the strobe.

The bench drives the pins and the bus 1 time unit after a rising edge and samples 1 unit after an edge. For each timing requirement it checks both the cycle before the result is due and the cycle it is due. The acknowledge race is produced by placing the acknowledge write on exactly the third edge after a fresh rising pin.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    typedef enum logic [2:0] {
        SEL_MODE   = 3'd0,
        SEL_SENSE  = 3'd1,
        SEL_ACK    = 3'd2,
        SEL_ENABLE = 3'd3,
        SEL_FILTER = 3'd4,
        SEL_STATUS = 3'd5
    } reg_sel_e;

    typedef enum logic {
        FLT_STEADY = 1'b0,
        FLT_SETTLE = 1'b1
    } flt_state_e;

endpackage

// File: rtl/gpio_irq_filter.sv
module gpio_irq_filter
    import gpio_irq_pkg::*;
#(
    parameter int DB_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic sync_o,
    output logic filt_o
);
    localparam int CW = (DB_LEN > 2) ? $clog2(DB_LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(DB_LEN - 1);

    logic [1:0]   meta_q;
    flt_state_e   state_q, state_n;
    logic [CW-1:0] cnt_q, cnt_n;
    logic         filt_q, filt_n;
    logic         differ;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) meta_q <= '0;
        else        meta_q <= {meta_q[0], pin};
    end

    assign sync_o = meta_q[1];
    assign differ = sync_o ^ filt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLT_STEADY;
            cnt_q   <= '0;
            filt_q  <= 1'b0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
            filt_q  <= filt_n;
        end
    end

    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        filt_n  = filt_q;
        unique case (state_q)
            FLT_STEADY: begin
                if (differ) begin
                    state_n = FLT_SETTLE;
                    cnt_n   = CW'(1);
                end
            end
            FLT_SETTLE: begin
                if (!differ) begin
                    state_n = FLT_STEADY;
                    cnt_n   = '0;
                end else if (cnt_q == LAST) begin
                    state_n = FLT_STEADY;
                    cnt_n   = '0;
                    filt_n  = sync_o;
                end else begin
                    cnt_n = cnt_q + CW'(1);
                end
            end
            default: begin
                state_n = FLT_STEADY;
                cnt_n   = '0;
            end
        endcase
    end

    assign filt_o = filt_q;

    property p_filter_full_run;
        @(posedge clk) disable iff (!rst_n)
        !$stable(filt_q) |-> ($past(cnt_q) == LAST && $past(state_q) == FLT_SETTLE);
    endproperty
    AST_FILTER_FULL_RUN: assert property (p_filter_full_run); // R10

endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int N_PINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        bus_addr,
    input  logic              bus_we,
    input  logic [N_PINS-1:0] bus_wdata,
    input  logic [N_PINS-1:0] status,
    output logic [N_PINS-1:0] bus_rdata,
    output logic [N_PINS-1:0] mode,
    output logic [N_PINS-1:0] sense,
    output logic [N_PINS-1:0] enable,
    output logic [N_PINS-1:0] filt_en,
    output logic [N_PINS-1:0] ack
);
    reg_sel_e sel;
    assign sel = reg_sel_e'(bus_addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode    <= '0;
            sense   <= '0;
            enable  <= '0;
            filt_en <= '0;
        end else if (bus_we) begin
            case (sel)
                SEL_MODE:   mode    <= bus_wdata;
                SEL_SENSE:  sense   <= bus_wdata;
                SEL_ENABLE: enable  <= bus_wdata;
                SEL_FILTER: filt_en <= bus_wdata;
                default: ;
            endcase
        end
    end

    assign ack = (bus_we && sel == SEL_ACK) ? bus_wdata : '0;

    always_comb begin
        case (sel)
            SEL_MODE:   bus_rdata = mode;
            SEL_SENSE:  bus_rdata = sense;
            SEL_ENABLE: bus_rdata = enable;
            SEL_FILTER: bus_rdata = filt_en;
            SEL_STATUS: bus_rdata = status;
            default:    bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
    parameter int N_PINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] qual,
    input  logic [N_PINS-1:0] mode,
    input  logic [N_PINS-1:0] sense,
    input  logic [N_PINS-1:0] enable,
    input  logic [N_PINS-1:0] ack,
    output logic [N_PINS-1:0] status
);
    logic [N_PINS-1:0] prev_q, pend_q;
    logic [N_PINS-1:0] rise, fall, hit, evt, lvl;

    assign rise = qual & ~prev_q;
    assign fall = ~qual & prev_q;
    assign hit  = (sense & rise) | (~sense & fall);
    assign evt  = mode & enable & hit;
    assign lvl  = (sense & qual) | (~sense & ~qual);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            pend_q <= '0;
        end else begin
            prev_q <= qual;
            pend_q <= (pend_q & ~ack) | evt;
        end
    end

    assign status = enable & ((mode & pend_q) | (~mode & lvl));

    property p_edge_needs_event;
        @(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(evt)) == '0);
    endproperty
    AST_EDGE_NEEDS_EVENT: assert property (p_edge_needs_event); // R3

    property p_ack_clears;
        @(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & $past(ack & ~evt)) == '0);
    endproperty
    AST_ACK_CLEARS: assert property (p_ack_clears); // R6

    property p_ack_race_keeps;
        @(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & $past(evt)) == $past(evt));
    endproperty
    AST_ACK_RACE_KEEPS: assert property (p_ack_race_keeps); // R7

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
    parameter int N_PINS = 8,
    parameter int DB_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pin_in,
    input  logic [2:0]        bus_addr,
    input  logic              bus_we,
    input  logic [N_PINS-1:0] bus_wdata,
    output logic [N_PINS-1:0] bus_rdata,
    output logic [N_PINS-1:0] irq_line,
    output logic              irq_any
);
    logic [N_PINS-1:0] mode, sense, enable, filt_en, ack;
    logic [N_PINS-1:0] sync_v, filt_v, qual, status;

    gpio_irq_regs #(.N_PINS(N_PINS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .status    (status),
        .bus_rdata (bus_rdata),
        .mode      (mode),
        .sense     (sense),
        .enable    (enable),
        .filt_en   (filt_en),
        .ack       (ack)
    );

    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
        gpio_irq_filter #(.DB_LEN(DB_LEN)) u_filter (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin    (pin_in[i]),
            .sync_o (sync_v[i]),
            .filt_o (filt_v[i])
        );
        assign qual[i] = filt_en[i] ? filt_v[i] : sync_v[i];
    end

    gpio_irq_detect #(.N_PINS(N_PINS)) u_detect (
        .clk    (clk),
        .rst_n  (rst_n),
        .qual   (qual),
        .mode   (mode),
        .sense  (sense),
        .enable (enable),
        .ack    (ack),
        .status (status)
    );

    assign irq_line = status;
    assign irq_any  = |status;

endmodule

// File: tb/test_gpio_irq_unit.sv
module test_gpio_irq_unit;
    localparam int CLK_PERIOD = 10;
    localparam logic [2:0] A_MODE = 3'd0, A_SENSE = 3'd1, A_ACK = 3'd2,
                           A_EN = 3'd3, A_FILT = 3'd4, A_STAT = 3'd5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pin_in = '0;
    logic [2:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata, irq_line;
    logic       irq_any;
    int         checks = 0;
    int         failures = 0;
    bit         done = 1'b0;

    gpio_irq_unit i_gpio_irq_unit (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_line(irq_line), .irq_any(irq_any)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        wait_clk(1);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic clear_cfg();
        wr(A_EN, 8'h00); wr(A_MODE, 8'h00); wr(A_SENSE, 8'h00); wr(A_FILT, 8'h00);
        pin_in = '0;
        wait_clk(8);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(A_MODE, v);  chk("R1 mode", v, 8'h00);
        rd(A_SENSE, v); chk("R1 sense", v, 8'h00);
        rd(A_EN, v);    chk("R1 enable", v, 8'h00);
        rd(A_FILT, v);  chk("R1 filter", v, 8'h00);
        rd(A_STAT, v);  chk("R1 status", v, 8'h00);
        chk("R1 irq_line", irq_line, 8'h00);
        chk("R1 irq_any", {7'd0, irq_any}, 8'h00);
    endtask

    task automatic t_regmap();
        logic [7:0] v;
        wr(A_STAT, 8'hFF);
        rd(A_STAT, v); chk("R2 status write ignored", v, 8'h00);
        wr(A_MODE, 8'hA5);  rd(A_MODE, v);  chk("R2 mode rb", v, 8'hA5);
        wr(A_SENSE, 8'h3C); rd(A_SENSE, v); chk("R2 sense rb", v, 8'h3C);
        wr(A_FILT, 8'h0F);  rd(A_FILT, v);  chk("R2 filter rb", v, 8'h0F);
        wr(A_EN, 8'hF0);    rd(A_EN, v);    chk("R2 enable rb", v, 8'hF0);
        rd(A_ACK, v); chk("R2 ack reads 0", v, 8'h00);
        clear_cfg();
    endtask

    task automatic t_rise();
        logic [7:0] v;
        wr(A_MODE, 8'h01); wr(A_SENSE, 8'h01); wr(A_EN, 8'h01);
        pin_in[0] = 1'b1;
        wait_clk(2); chk("R3 R11 not before edge 3", irq_line, 8'h00);
        wait_clk(1); chk("R3 R11 set at edge 3", irq_line, 8'h01);
        chk("R9 any", {7'd0, irq_any}, 8'h01);
        pin_in[0] = 1'b0;
        wait_clk(5); rd(A_STAT, v); chk("R3 held after pin low", v, 8'h01);
        wr(A_ACK, 8'hFE); rd(A_STAT, v); chk("R6 zero bits no effect", v, 8'h01);
        wr(A_ACK, 8'h01); rd(A_STAT, v); chk("R6 cleared", v, 8'h00);
        chk("R9 any low", {7'd0, irq_any}, 8'h00);
        clear_cfg();
    endtask

    task automatic t_fall();
        pin_in[1] = 1'b1; wait_clk(4);
        wr(A_MODE, 8'h02); wr(A_SENSE, 8'h00); wr(A_EN, 8'h02);
        chk("R4 idle", irq_line, 8'h00);
        pin_in[1] = 1'b0;
        wait_clk(2); chk("R4 not before edge 3", irq_line, 8'h00);
        wait_clk(1); chk("R4 falling sets", irq_line, 8'h02);
        wr(A_ACK, 8'h02);
        pin_in[1] = 1'b1; wait_clk(5);
        chk("R4 rising ignored", irq_line, 8'h00);
        clear_cfg();
    endtask

    task automatic t_level();
        logic [7:0] v;
        wr(A_MODE, 8'h00); wr(A_SENSE, 8'h04); wr(A_EN, 8'h04);
        chk("R5 low input inactive", irq_line, 8'h00);
        pin_in[2] = 1'b1;
        wait_clk(1); chk("R5 not at edge 1", irq_line, 8'h00);
        wait_clk(1); chk("R5 high at edge 2", irq_line, 8'h04);
        wr(A_ACK, 8'h04); rd(A_STAT, v); chk("R5 ack no effect", v, 8'h04);
        pin_in[2] = 1'b0;
        wait_clk(2); chk("R5 follows low", irq_line, 8'h00);
        wr(A_EN, 8'h00); wr(A_SENSE, 8'h00); wr(A_EN, 8'h04);
        chk("R5 active-low", irq_line, 8'h04);
        clear_cfg();
    endtask

    task automatic t_enable();
        wr(A_MODE, 8'h08); wr(A_SENSE, 8'h08);
        pin_in[3] = 1'b1; wait_clk(4);
        chk("R8 disabled no irq", irq_line, 8'h00);
        chk("R8 disabled no any", {7'd0, irq_any}, 8'h00);
        wr(A_EN, 8'h08); wait_clk(1);
        chk("R8 edge not recorded", irq_line, 8'h00);
        clear_cfg();
    endtask

    task automatic t_race();
        wr(A_MODE, 8'h10); wr(A_SENSE, 8'h10); wr(A_EN, 8'h10);
        pin_in[4] = 1'b1; wait_clk(3);
        chk("R7 first edge", irq_line, 8'h10);
        pin_in[4] = 1'b0; wait_clk(3);
        pin_in[4] = 1'b1; wait_clk(2);
        wr(A_ACK, 8'h10);
        chk("R7 ack with new edge keeps bit", irq_line, 8'h10);
        wr(A_ACK, 8'h10);
        chk("R7 later ack clears", irq_line, 8'h00);
        clear_cfg();
    endtask

    task automatic t_filter();
        wr(A_MODE, 8'h20); wr(A_SENSE, 8'h20); wr(A_FILT, 8'h20); wr(A_EN, 8'h20);
        pin_in[5] = 1'b1; wait_clk(3); pin_in[5] = 1'b0;
        wait_clk(10); chk("R10 3-clock pulse ignored", irq_line, 8'h00);
        pin_in[5] = 1'b1;
        wait_clk(6); chk("R10 not before edge 7", irq_line, 8'h00);
        wait_clk(1); chk("R10 set at edge 7", irq_line, 8'h20);
        clear_cfg();
    endtask

    task automatic t_multi();
        wr(A_MODE, 8'hC0); wr(A_SENSE, 8'hC0); wr(A_EN, 8'hC0);
        pin_in[7:6] = 2'b11; wait_clk(3);
        chk("R9 two lines", irq_line, 8'hC0);
        wr(A_ACK, 8'h40);
        chk("R9 one left", irq_line, 8'h80);
        chk("R9 any still high", {7'd0, irq_any}, 8'h01);
        wr(A_ACK, 8'h80);
        chk("R9 any low", {7'd0, irq_any}, 8'h00);
        clear_cfg();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(1);
        t_reset();
        t_regmap();
        t_rise();
        t_fall();
        t_level();
        t_enable();
        t_race();
        t_filter();
        t_multi();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule